// File: doc/BRIEF.md
# Single-Wire Pulse-Width LED Encoder

This block turns a stream of 24-bit pixel words into the self-clocked waveform that daisy-chained addressable LEDs expect on one data wire. Every bit takes one frame of ten ticks. The line is low for three ticks and then high for two. For the last five ticks it stays high if the bit is a one and goes low if the bit is a zero. Each pixel word carries its green byte, then its red byte, then its blue byte, and the most significant bit is sent first.

A tick is one period of a programmable divider that runs from the system clock. Software chooses the divider so that ten ticks match the LED's nominal bit period of about 1.25 µs. Pixel words arrive through a valid/ready handshake. The encoder accepts a new word only when its shift register is empty: either when it is idle, or on the final tick of the last bit of the current word. A producer that keeps data ready therefore gets a gapless stream. When no word is waiting, the line rests low and `busy` drops. After a programmable number of low cycles, `latched` reports that the LEDs have seen their latch/reset gap.

Top module: `led_line_encoder`

## Requirements
- R1: After reset, `line_out` is low, `busy` is low and `pix_ready` is high.
- R2: A one bit shows on `line_out` as 3 ticks low followed by 7 ticks high.
- R3: A zero bit shows on `line_out` as 3 ticks low, then 2 ticks high, then 5 ticks low. The line is therefore high for 2 ticks and low for 8 ticks in each zero bit.
- R4: Each word is sent as 24 bits, starting at bit 23 and ending at bit 0. Bits 23:16 are green, bits 15:8 are red and bits 7:0 are blue.
- R5: One tick lasts `div_cfg`+1 clock cycles. This holds for the first frame that starts from idle as well. A single word keeps `busy` high for exactly 240·(`div_cfg`+1) cycles.
- R6: `pix_ready` is high only while the encoder is idle or during the final tick cycle of a word's last bit. While a word is being sent at any other point, `pix_ready` is low. Each accepted word is sent exactly once.
- R7: A word offered while the current word is being sent is taken at the word boundary. It follows with no extra low time, and `busy` stays high across the boundary.
- R8: When no word is waiting at a word boundary, `busy` falls and `line_out` stays low from the next cycle on.
- R9: `latched` is high only when the encoder is idle and at least `latch_cfg` cycles have passed since `busy` fell. Counting starts at 0 in the first idle cycle. `latched` is low whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W (16) | Tick divider; a tick lasts div_cfg+1 cycles |
| latch_cfg | input | LATCH_W (16) | Idle cycles before `latched` asserts |
| pix_data | input | 24 | Pixel word, green in 23:16, red in 15:8, blue in 7:0 |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Encoder accepts the offered word on this edge |
| line_out | output | 1 | Serial LED data line |
| busy | output | 1 | A word is being sent |
| latched | output | 1 | Line has been idle low for at least latch_cfg cycles |

## Verification
The single-word vectors use an all-zero word, an all-one word, a word with only its two end bits set, and mixed patterns. These words are sent at divider values 0 through 3. They separate high runs of two ticks from high runs of seven ticks, detect a reversed bit order, and expose a tick length that does not scale with the divider. A run of three words offered back to back shows whether data is dropped or repeated at a word boundary, and whether idle time is inserted there. Low-run lengths of 3 and 8 ticks between bits are checked inside words and across word boundaries. A latch window test confirms that `latched` asserts on exactly the cycle where the idle count reaches its threshold.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    localparam int FRAME_TICKS = 10;
    localparam int LOW_TICKS   = 3;
    localparam int LEAD_TICKS  = 2;
    localparam int PIX_W       = 24;
    localparam int PH_W        = $clog2(FRAME_TICKS);
    localparam int BIT_W       = $clog2(PIX_W);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_e;

    // Line level for a given tick inside a frame and the data bit carried.
    function automatic logic frame_level(input logic [PH_W-1:0] phase,
                                         input logic            data_bit);
        if (phase < PH_W'(LOW_TICKS))
            return 1'b0;
        else if (phase < PH_W'(LOW_TICKS + LEAD_TICKS))
            return 1'b1;
        else
            return data_bit;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_q, r_d;

    assign tick = !clr && (r_q.cnt == div_cfg);

    always_comb begin
        r_d = r_q;
        if (clr || r_q.cnt == div_cfg)
            r_d.cnt = '0;
        else
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

endmodule

// File: rtl/led_bit_shifter.sv
module led_bit_shifter
    import led_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    output logic             busy,
    output logic             line_out
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(FRAME_TICKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PIX_W - 1);

    typedef struct packed {
        enc_state_e       state;
        logic [PIX_W-1:0] shift;
        logic [PH_W-1:0]  phase;
        logic [BIT_W-1:0] bitno;
        logic             line;
    } shf_reg_t;

    shf_reg_t r_q, r_d;
    logic     last_tick;
    logic     take;

    assign last_tick = (r_q.state == ST_SEND) && tick &&
                       (r_q.phase == PH_LAST) && (r_q.bitno == BIT_LAST);
    assign pix_ready = (r_q.state == ST_IDLE) || last_tick;
    assign take      = pix_ready && pix_valid;
    assign busy      = (r_q.state == ST_SEND);
    assign line_out  = r_q.line;

    always_comb begin
        r_d = r_q;
        r_d.line = (r_q.state == ST_SEND) &&
                   frame_level(r_q.phase, r_q.shift[PIX_W-1]);
        if (r_q.state == ST_IDLE) begin
            if (take) begin
                r_d.state = ST_SEND;
                r_d.shift = pix_data;
                r_d.phase = '0;
                r_d.bitno = '0;
            end
        end else if (tick) begin
            if (r_q.phase == PH_LAST) begin
                r_d.phase = '0;
                if (r_q.bitno == BIT_LAST) begin
                    r_d.bitno = '0;
                    if (take)
                        r_d.shift = pix_data;
                    else
                        r_d.state = ST_IDLE;
                end else begin
                    r_d.shift = {r_q.shift[PIX_W-2:0], 1'b0};
                    r_d.bitno = r_q.bitno + 1'b1;
                end
            end else begin
                r_d.phase = r_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> (busy && r_q.phase == '0 && r_q.bitno == '0)); // R6

    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(r_q.phase)); // R5

endmodule

// File: rtl/led_latch_timer.sv
module led_latch_timer #(
    parameter int LATCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic [LATCH_W-1:0] latch_cfg,
    output logic               latched
);

    typedef struct packed {
        logic [LATCH_W-1:0] cnt;
    } lat_reg_t;

    lat_reg_t r_q, r_d;

    assign latched = !busy && (r_q.cnt >= latch_cfg);

    always_comb begin
        r_d = r_q;
        if (busy)
            r_d.cnt = '0;
        else if (r_q.cnt != '1)
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

endmodule

// File: rtl/led_line_encoder.sv
module led_line_encoder
    import led_enc_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int LATCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [LATCH_W-1:0] latch_cfg,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic               pix_valid,
    output logic               pix_ready,
    output logic               line_out,
    output logic               busy,
    output logic               latched
);

    logic tick;

    led_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!busy),
        .div_cfg (div_cfg),
        .tick    (tick)
    );

    led_bit_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .busy      (busy),
        .line_out  (line_out)
    );

    led_latch_timer #(.LATCH_W(LATCH_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .latch_cfg (latch_cfg),
        .latched   (latched)
    );

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !line_out); // R8

    AST_LATCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !latched); // R9

    AST_RISE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_out) |-> busy); // R2

endmodule

// File: tb/led_line_encoder_tb.sv
`timescale 1ns/1ps
module led_line_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_cfg = 16'd0;
    logic [15:0] latch_cfg = 16'd40;
    logic [23:0] pix_data = 24'd0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, line_out, busy, latched;

    always #2 clk = ~clk;

    led_line_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .latch_cfg(latch_cfg),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .line_out(line_out), .busy(busy), .latched(latched)
    );

    int tests = 0;
    int fails = 0;

    // {divider, word}
    localparam logic [39:0] VEC [6] = '{
        {16'd0, 24'hA5C33C},
        {16'd1, 24'h000000},
        {16'd2, 24'hFFFFFF},
        {16'd0, 24'h800001},
        {16'd3, 24'h123456},
        {16'd1, 24'h5A0FF0}
    };

    // Waveform decoder: run lengths on line_out, measured in cycles.
    int          cur_d = 1;
    logic        prev_line = 1'b0;
    logic        prev_busy = 1'b0;
    int          run = 0;
    logic        have_prev = 1'b0;
    logic        last_bit = 1'b0;
    logic        gap_seen = 1'b1;
    int          bad_runs = 0;
    int          busy_cyc = 0;
    int          busy_falls = 0;
    logic [23:0] acc = 24'd0;
    int          acc_n = 0;
    logic [23:0] cap [0:15];
    int          cap_n = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            run = 0;
        end else begin
            if (busy) busy_cyc++;
            else gap_seen = 1'b1;
            if (prev_busy && !busy) busy_falls++;
            prev_busy = busy;
            if (line_out != prev_line) begin
                if (prev_line) begin
                    if (run == 7 * cur_d)      last_bit = 1'b1;
                    else if (run == 2 * cur_d) last_bit = 1'b0;
                    else bad_runs++;
                    have_prev = 1'b1;
                    acc = {acc[22:0], last_bit};
                    acc_n++;
                    if (acc_n == 24) begin
                        if (cap_n < 16) cap[cap_n] = acc;
                        cap_n++;
                        acc_n = 0;
                    end
                    gap_seen = 1'b0;
                end else begin
                    if (have_prev && !gap_seen &&
                        run != (last_bit ? 3 * cur_d : 8 * cur_d))
                        bad_runs++;
                end
                run = 1;
            end else begin
                run++;
            end
            prev_line = line_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = w;
        while (!pix_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic drop_and_drain();
        @(negedge clk);
        pix_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base, bad0, cyc0, fall0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(line_out == 1'b0, "R1", "line after reset", line_out, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(pix_ready == 1'b1, "R1", "ready after reset", pix_ready, 1);

        // Vector table: R2 R3 R4 R5 R8
        for (int i = 0; i < 6; i++) begin
            div_cfg = VEC[i][39:24];
            cur_d   = int'(VEC[i][39:24]) + 1;
            base = cap_n; bad0 = bad_runs; cyc0 = busy_cyc;
            send_word(VEC[i][23:0]);
            drop_and_drain();
            check(cap_n == base + 1, "R6", "words seen", cap_n - base, 1);
            check(cap[base] == VEC[i][23:0], "R4", "decoded word",
                  cap[base], VEC[i][23:0]);
            check(bad_runs == bad0, "R2/R3 pulse widths R2 R3", "bad runs",
                  bad_runs - bad0, 0);
            check(busy_cyc - cyc0 == 240 * cur_d, "R5", "busy cycles",
                  busy_cyc - cyc0, 240 * cur_d);
            check(!line_out && !busy, "R8", "idle line/busy",
                  {line_out, busy}, 0);
        end

        // Back-to-back stream: R7 R6
        div_cfg = 16'd2; cur_d = 3;
        base = cap_n; bad0 = bad_runs; cyc0 = busy_cyc; fall0 = busy_falls;
        send_word(24'hF0F0F0);
        send_word(24'h0F0F0F);
        send_word(24'h3C3C3C);
        drop_and_drain();
        check(busy_falls - fall0 == 1, "R7", "busy drops", busy_falls - fall0, 1);
        check(busy_cyc - cyc0 == 720 * cur_d, "R7", "stream cycles",
              busy_cyc - cyc0, 720 * cur_d);
        check(cap_n - base == 3, "R6", "stream words", cap_n - base, 3);
        check(cap[base] == 24'hF0F0F0, "R7", "word 0", cap[base], 24'hF0F0F0);
        check(cap[base+1] == 24'h0F0F0F, "R7", "word 1", cap[base+1], 24'h0F0F0F);
        check(cap[base+2] == 24'h3C3C3C, "R7", "word 2", cap[base+2], 24'h3C3C3C);
        check(bad_runs == bad0, "R7", "boundary low runs", bad_runs - bad0, 0);

        // Mid-word status and latch window: R6 R9
        div_cfg = 16'd1; cur_d = 2; latch_cfg = 16'd40;
        send_word(24'h00FF00);
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(pix_ready == 1'b0, "R6", "ready mid-word", pix_ready, 0);
        check(busy == 1'b1, "R6", "busy mid-word", busy, 1);
        check(latched == 1'b0, "R9", "latched while busy", latched, 0);
        while (busy) @(negedge clk);
        check(latched == 1'b0, "R9", "latched at idle 0", latched, 0);
        repeat (39) @(negedge clk);
        check(latched == 1'b0, "R9", "latched at idle 39", latched, 0);
        @(negedge clk);
        check(latched == 1'b1, "R9", "latched at idle 40", latched, 1);
        check(line_out == 1'b0, "R8", "line during latch gap", line_out, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule